// File: doc/BRIEF.md
# Configuration request TLP packer

The block turns one configuration-space access into a PCI Express configuration request packet. A request carries a read/write flag, the target bus number, the device/function byte, a byte offset, an access size in bytes (1, 2 or 4) and the write data. From these the block derives the byte enables, moves the write data into the addressed byte lanes and builds the three header dwords. It then emits the packet as 64-bit beats. Each beat holds two 32-bit words, and start-of-packet and end-of-packet flags mark its ends.

The block keeps the root bus number in a register. That register decides between Type 0 requests (target on the root bus) and Type 1 requests (target beyond it), and it supplies the requester ID. A write packet to the root bus at the primary-bus register offset reloads it. The request side and the beat side each use a valid/ready handshake. Only one packet is in flight at a time.

Top module: `cfg_tlp_packer`

## Requirements
- R1: After reset, req_ready_o is 1, beat_valid_o is 0 and root_bus_o is 0.
- R2: Header dword 0 is {fmt, 24'h000001}. fmt is 0x04 for a Type 0 read, 0x44 for a Type 0 write, 0x05 for a Type 1 read and 0x45 for a Type 1 write. Type 0 is chosen when req_bus_i equals root_bus_o at acceptance.
- R3: Header dword 1 is {root_bus, 8'h00, tag, byte_enables}. tag is 0x1D for a read and 0x10 for a write.
- R4: The 8-bit byte-enable field is 8'h01 << off[1:0] for size 1, 8'h03 << off[1:0] for size 2, and 8'h0F for any other size value. Reads and writes use the same rule.
- R5: Header dword 2 is {bus, devfn, off16}. off16 is the offset zero-extended to 16 bits with bits [1:0] cleared.
- R6: Write data is masked to the low 8 bits (size 1), to the low 16 bits (size 2), or not at all (other sizes). It is then shifted left by 8*off[1:0], with the result truncated to 32 bits. A read carries zero data.
- R7: Beats are {hi, lo} words on beat_hi_o and beat_lo_o. A write with off[2:0]==0 takes three beats: {dw1, dw0} with SOP; {0, dw2} with no flag; {0, data} with EOP.
- R8: Every other packet takes two beats: {dw1, dw0} with SOP, then {data, dw2} with EOP. This covers every read, and a read always uses this form.
- R9: req_ready_o is 0 while a packet is in progress. A beat presented without beat_ready_i stays unchanged on the next cycle.
- R10: The root bus register loads the low byte of the aligned write data. This happens when the EOP beat of a Type 0 write whose dword-aligned offset is 0x18 is accepted. No other packet changes the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bus_i | input | 8 | Target bus number |
| req_devfn_i | input | 8 | Target device/function |
| req_off_i | input | OFF_W | Byte offset in configuration space |
| req_size_i | input | 3 | Access size in bytes |
| req_wdata_i | input | 32 | Write value, right-justified |
| beat_valid_o | output | 1 | Beat valid |
| beat_ready_i | input | 1 | Downstream takes the beat |
| beat_lo_o | output | 32 | First word of the beat |
| beat_hi_o | output | 32 | Second word of the beat |
| beat_sop_o | output | 1 | First beat of a packet |
| beat_eop_o | output | 1 | Last beat of a packet |
| root_bus_o | output | 8 | Stored root bus number |

## Verification
The bench builds the block with its default 12-bit offset and the primary-bus offset of 0x18. This lets random offsets reach both beat layouts, every byte lane and the upper offset bits that are dropped from the aligned field. Directed writes to offsets 0x18 and 0x19 of the root bus move the root number. Later requests then flip between Type 0 and Type 1 and show a requester ID that changes. Random downstream stalls hold every beat position for several cycles.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;
  localparam int unsigned DW = 32;
  localparam logic [7:0] FMT_RD_T0 = 8'h04;
  localparam logic [7:0] FMT_WR_T0 = 8'h44;
  localparam logic [7:0] FMT_RD_T1 = 8'h05;
  localparam logic [7:0] FMT_WR_T1 = 8'h45;
  localparam logic [7:0] TAG_RD    = 8'h1D;
  localparam logic [7:0] TAG_WR    = 8'h10;
  localparam logic [23:0] LEN_ONE  = 24'h000001;

  typedef struct packed {
    logic [DW-1:0] dw0;
    logic [DW-1:0] dw1;
    logic [DW-1:0] dw2;
    logic [DW-1:0] data;
    logic          three_beat;
    logic          root_upd;
  } cfg_pkt_t;

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_MID, S_DATA} seq_state_e;
endpackage

// File: rtl/cfg_be_align.sv
module cfg_be_align
  import cfg_tlp_pkg::*;
(
  input  logic [2:0]    size_i,
  input  logic [1:0]    lane_i,
  input  logic [DW-1:0] wdata_i,
  output logic [7:0]    be_o,
  output logic [DW-1:0] data_o
);
  logic [4:0] shamt;
  assign shamt = {lane_i, 3'b000};

  always_comb begin
    unique case (size_i)
      3'd1: begin
        be_o   = 8'h01 << lane_i;
        data_o = (wdata_i & 32'h0000_00FF) << shamt;
      end
      3'd2: begin
        be_o   = 8'h03 << lane_i;
        data_o = (wdata_i & 32'h0000_FFFF) << shamt;
      end
      default: begin
        be_o   = 8'h0F;
        data_o = wdata_i;
      end
    endcase
  end
endmodule

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build
  import cfg_tlp_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter logic [OFF_W-1:0] PRIMARY_OFF = OFF_W'(8'h18)
) (
  input  logic             write_i,
  input  logic [7:0]       bus_i,
  input  logic [7:0]       devfn_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       root_bus_i,
  input  logic [7:0]       be_i,
  input  logic [DW-1:0]    data_i,
  output cfg_pkt_t         pkt_o
);
  logic             type0;
  logic [7:0]       fmt;
  logic [OFF_W-1:0] off_al;
  logic [15:0]      off16;

  assign type0  = (bus_i == root_bus_i);
  assign off_al = off_i & ~OFF_W'(3);
  assign off16  = 16'(off_al);

  always_comb begin
    unique case ({write_i, type0})
      2'b01:   fmt = FMT_RD_T0;
      2'b00:   fmt = FMT_RD_T1;
      2'b11:   fmt = FMT_WR_T0;
      default: fmt = FMT_WR_T1;
    endcase
  end

  always_comb begin
    pkt_o.dw0        = {fmt, LEN_ONE};
    pkt_o.dw1        = {root_bus_i, 8'h00, (write_i ? TAG_WR : TAG_RD), be_i};
    pkt_o.dw2        = {bus_i, devfn_i, off16};
    pkt_o.data       = write_i ? data_i : '0;
    pkt_o.three_beat = write_i && (off_i[2:0] == 3'b000);
    pkt_o.root_upd   = write_i && type0 && (off_al == PRIMARY_OFF);
  end
endmodule

// File: rtl/cfg_root_reg.sv
module cfg_root_reg #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  logic [7:0] upd_val_i,
  output logic [7:0] root_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    root_o <= RST_VAL;
    else if (upd_i) root_o <= upd_val_i;
  end
endmodule

// File: rtl/cfg_beat_seq.sv
module cfg_beat_seq
  import cfg_tlp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  cfg_pkt_t      pkt_i,
  output logic          beat_valid_o,
  input  logic          beat_ready_i,
  output logic [DW-1:0] beat_lo_o,
  output logic [DW-1:0] beat_hi_o,
  output logic          beat_sop_o,
  output logic          beat_eop_o,
  output logic          upd_o,
  output logic [7:0]    upd_val_o
);
  seq_state_e state_q, state_d;
  cfg_pkt_t   pkt_q;
  logic       accept, fire;

  assign req_ready_o = (state_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign fire        = beat_valid_o && beat_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pkt_q <= '0;
    else if (accept) pkt_q <= pkt_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) state_d = S_HDR;
      S_HDR:  if (fire)   state_d = S_MID;
      S_MID:  if (fire)   state_d = pkt_q.three_beat ? S_DATA : S_IDLE;
      default: if (fire)  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    beat_valid_o = 1'b1;
    beat_sop_o   = 1'b0;
    beat_eop_o   = 1'b0;
    beat_lo_o    = '0;
    beat_hi_o    = '0;
    unique case (state_q)
      S_IDLE: beat_valid_o = 1'b0;
      S_HDR: begin
        beat_lo_o  = pkt_q.dw0;
        beat_hi_o  = pkt_q.dw1;
        beat_sop_o = 1'b1;
      end
      S_MID: begin
        beat_lo_o  = pkt_q.dw2;
        beat_hi_o  = pkt_q.three_beat ? '0 : pkt_q.data;
        beat_eop_o = !pkt_q.three_beat;
      end
      default: begin
        beat_lo_o  = pkt_q.data;
        beat_eop_o = 1'b1;
      end
    endcase
  end

  assign upd_o     = fire && beat_eop_o && pkt_q.root_upd;
  assign upd_val_o = pkt_q.data[7:0];
endmodule

// File: rtl/cfg_tlp_packer.sv
module cfg_tlp_packer
  import cfg_tlp_pkg::*;
#(
  parameter int unsigned OFF_W = 12,
  parameter logic [OFF_W-1:0] PRIMARY_OFF = OFF_W'(8'h18),
  parameter logic [7:0] ROOT_RST = 8'h00
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [7:0]       req_bus_i,
  input  logic [7:0]       req_devfn_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [2:0]       req_size_i,
  input  logic [31:0]      req_wdata_i,
  output logic             beat_valid_o,
  input  logic             beat_ready_i,
  output logic [31:0]      beat_lo_o,
  output logic [31:0]      beat_hi_o,
  output logic             beat_sop_o,
  output logic             beat_eop_o,
  output logic [7:0]       root_bus_o
);
  logic [7:0]    be;
  logic [DW-1:0] data_al;
  cfg_pkt_t      pkt;
  logic          upd;
  logic [7:0]    upd_val;

  cfg_be_align u_align (
    .size_i  (req_size_i),
    .lane_i  (req_off_i[1:0]),
    .wdata_i (req_wdata_i),
    .be_o    (be),
    .data_o  (data_al)
  );

  cfg_hdr_build #(.OFF_W(OFF_W), .PRIMARY_OFF(PRIMARY_OFF)) u_hdr (
    .write_i    (req_write_i),
    .bus_i      (req_bus_i),
    .devfn_i    (req_devfn_i),
    .off_i      (req_off_i),
    .root_bus_i (root_bus_o),
    .be_i       (be),
    .data_i     (data_al),
    .pkt_o      (pkt)
  );

  cfg_beat_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .pkt_i        (pkt),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .beat_lo_o    (beat_lo_o),
    .beat_hi_o    (beat_hi_o),
    .beat_sop_o   (beat_sop_o),
    .beat_eop_o   (beat_eop_o),
    .upd_o        (upd),
    .upd_val_o    (upd_val)
  );

  cfg_root_reg #(.RST_VAL(ROOT_RST)) u_root (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd),
    .upd_val_i (upd_val),
    .root_o    (root_bus_o)
  );
endmodule

// File: rtl/cfg_tlp_packer_chk.sv
module cfg_tlp_packer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        beat_valid_o,
  input logic        beat_ready_i,
  input logic [31:0] beat_lo_o,
  input logic [31:0] beat_hi_o,
  input logic        beat_sop_o,
  input logic        beat_eop_o,
  input logic [7:0]  root_bus_o
);
  // R9
  beat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_lo_o) &&
      $stable(beat_hi_o) && $stable(beat_sop_o) && $stable(beat_eop_o));
  // R9
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> !req_ready_o);
  // R7
  accept_sop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> beat_valid_o && beat_sop_o);
  // R8
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(beat_sop_o && beat_eop_o));
  // R10
  root_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(beat_valid_o && beat_ready_i && beat_eop_o) |=> $stable(root_bus_o));
endmodule

bind cfg_tlp_packer cfg_tlp_packer_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .beat_valid_o (beat_valid_o),
  .beat_ready_i (beat_ready_i),
  .beat_lo_o    (beat_lo_o),
  .beat_hi_o    (beat_hi_o),
  .beat_sop_o   (beat_sop_o),
  .beat_eop_o   (beat_eop_o),
  .root_bus_o   (root_bus_o)
);

// File: tb/sim_cfg_tlp_packer.sv
`timescale 1ns/1ps
module sim_cfg_tlp_packer;
  localparam int OFF_W = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, beat_ready = 0;
  logic [7:0] req_bus = 0, req_devfn = 0;
  logic [OFF_W-1:0] req_off = 0;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, beat_valid, beat_sop, beat_eop;
  logic [31:0] beat_lo, beat_hi;
  logic [7:0] root_bus;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] root_m = 8'h00;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_tlp_packer #(.OFF_W(OFF_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_bus_i(req_bus), .req_devfn_i(req_devfn),
    .req_off_i(req_off), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .beat_valid_o(beat_valid), .beat_ready_i(beat_ready), .beat_lo_o(beat_lo),
    .beat_hi_o(beat_hi), .beat_sop_o(beat_sop), .beat_eop_o(beat_eop),
    .root_bus_o(root_bus));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_be(input logic [2:0] sz, input logic [1:0] o);
    case (sz)
      3'd1: return 8'h01 << o;
      3'd2: return 8'h03 << o;
      default: return 8'h0F;
    endcase
  endfunction

  function automatic logic [31:0] exp_data(input logic [2:0] sz, input logic [1:0] o,
                                           input logic [31:0] w);
    case (sz)
      3'd1: return (w & 32'hFF) << (8 * o);
      3'd2: return (w & 32'hFFFF) << (8 * o);
      default: return w;
    endcase
  endfunction

  task automatic do_req(input logic wr, input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [OFF_W-1:0] off, input logic [2:0] sz,
                        input logic [31:0] wd, input int stall_pct);
    logic [31:0] lo[3], hi[3];
    logic sop[3], eop[3];
    logic t0, three;
    logic [7:0] fmt;
    logic [31:0] d, dw0, dw1, dw2;
    int nb, idx;
    string ftag;
    t0 = (bus == root_m);
    fmt = wr ? (t0 ? 8'h44 : 8'h45) : (t0 ? 8'h04 : 8'h05);
    d = wr ? exp_data(sz, off[1:0], wd) : 32'h0;
    dw0 = {fmt, 24'h000001};
    dw1 = {root_m, 8'h00, (wr ? 8'h10 : 8'h1D), exp_be(sz, off[1:0])};
    dw2 = {bus, devfn, 16'(off & ~OFF_W'(3))};
    three = wr && (off[2:0] == 3'b000);
    ftag = three ? "R7" : "R8";
    lo[0] = dw0; hi[0] = dw1; sop[0] = 1; eop[0] = 0;
    lo[1] = dw2; hi[1] = three ? 32'h0 : d; sop[1] = 0; eop[1] = !three;
    lo[2] = d;   hi[2] = 32'h0; sop[2] = 0; eop[2] = 1;
    nb = three ? 3 : 2;

    @(negedge clk);
    chk("R9 idle ready", {31'b0, req_ready}, 1);
    req_valid = 1; req_write = wr; req_bus = bus; req_devfn = devfn;
    req_off = off; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk("R9 busy", {31'b0, req_ready}, 0);
    idx = 0;
    while (idx < nb && !done) begin
      logic rdy;
      chk("R9 valid", {31'b0, beat_valid}, 1);
      if (idx == 0) begin
        chk("R2", beat_lo, lo[0]);
        chk("R3", {beat_hi[31:8], 8'h00}, {hi[0][31:8], 8'h00});
        chk("R4", {24'h0, beat_hi[7:0]}, {24'h0, hi[0][7:0]});
      end else if (idx == 1) begin
        chk("R5", beat_lo, lo[1]);
        chk("R6", beat_hi, hi[1]);
      end else begin
        chk("R6", beat_lo, lo[2]);
        chk("R7", beat_hi, hi[2]);
      end
      chk(ftag, {30'b0, beat_sop, beat_eop}, {30'b0, sop[idx], eop[idx]});
      rdy = ($urandom % 100) >= stall_pct;
      beat_ready = rdy;
      @(negedge clk);
      beat_ready = 0;
      if (rdy) idx++;
    end
    chk(ftag, {31'b0, beat_valid}, 0);
    if (wr && t0 && ((off & ~OFF_W'(3)) == OFF_W'(8'h18))) root_m = d[7:0];
    chk("R10", {24'h0, root_bus}, {24'h0, root_m});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1;
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 ready", {31'b0, req_ready}, 1);
    chk("R1 valid", {31'b0, beat_valid}, 0);
    chk("R1 root", {24'h0, root_bus}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 root after release", {24'h0, root_bus}, 0);

    // directed corners
    do_req(1, 8'h00, 8'h08, 12'h010, 3'd4, 32'hCAFE_F00D, 0);  // aligned write, type 0
    do_req(1, 8'h02, 8'h10, 12'h00D, 3'd1, 32'h0000_12AB, 50); // byte lane 1, type 1
    do_req(1, 8'h00, 8'h00, 12'h00F, 3'd2, 32'hFFFF_BEEF, 30); // size 2 at lane 3: be 0x18
    do_req(0, 8'h00, 8'h00, 12'h018, 3'd4, 32'h1234_5678, 0);  // read at 0x18: no update
    do_req(1, 8'h00, 8'h00, 12'h018, 3'd4, 32'h0000_0A05, 40); // root -> 05
    do_req(0, 8'h05, 8'h20, 12'h100, 3'd4, 32'h0, 0);          // now type 0
    do_req(0, 8'h00, 8'h20, 12'h100, 3'd4, 32'h0, 0);          // now type 1
    do_req(1, 8'h05, 8'h00, 12'h019, 3'd1, 32'h0000_0033, 0);  // low byte 0 -> root 00
    do_req(1, 8'h07, 8'h00, 12'h018, 3'd4, 32'h0000_0077, 0);  // type 1: no update
    do_req(1, 8'h00, 8'h00, 12'hFFE, 3'd3, 32'hA5A5_5A5A, 20); // size 3 -> dword

    for (int n = 0; n < 300 && !done; n++) begin
      logic [7:0] b;
      logic [2:0] sz;
      int sel;
      sel = $urandom % 3;
      b = (sel == 0) ? root_m : (sel == 1) ? root_m + 8'd1 : 8'($urandom);
      sel = $urandom % 4;
      sz = (sel == 0) ? 3'd1 : (sel == 1) ? 3'd2 : (sel == 2) ? 3'd4 : 3'($urandom);
      do_req(1'($urandom), b, 8'($urandom), OFF_W'($urandom), sz, $urandom, 35);
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule